// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block is the slave end of a stereo serial audio link. It watches a bit clock, a frame clock and a single data line, all produced elsewhere, and turns the stream into left and right PCM words. The three lines are brought into the local clock domain through a two-stage synchroniser. Every decision is then made on the detected rising edges of the bit clock, and the data line is sampled on those edges.

Two static configuration inputs select the justification scheme and the word length. Each finished sample appears on a 24-bit output for its channel. The sample sits in the upper bits with zeros below it, and a one-cycle strobe marks it. Frames of 32, 48 or 64 bit clocks are accepted, and the block finds the word boundaries from frame-clock transitions alone. It needs no knowledge of the frame length. Configuration is expected to change only while reset is held.

Top module: `serial_audio_rx`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both PCM outputs are zero and both strobes are low.
- R2: With `fmt` = 1 (left-justified), the MSB is the bit sampled on the first bit-clock rising edge after a frame-clock transition. A frame clock at 1 marks the left channel.
- R3: With `fmt` = 0 (I2S), the MSB is sampled on the second bit-clock rising edge after a transition, and a frame clock at 0 marks the left channel. When the word fills the half-frame, its LSB is the first bit of the following half-frame.
- R4: With `fmt` = 2 (right-justified), the LSB is the last bit before a frame-clock transition, and a frame clock at 1 marks the left channel. The word is delivered after the transition that closes its half-frame.
- R5: `wlen` codes 0, 1, 2 and 3 select 16, 18, 20 and 24-bit words. Bits of a half-frame outside the selected word have no effect on the output.
- R6: A delivered N-bit word occupies bits 23 down to 24-N of its output, and all bits below are zero.
- R7: Half-frames of 16, 24 and 32 bit clocks (frames of 32, 48, 64) work for every word length that fits the half-frame.
- R8: Each strobe lasts one clock cycle, and the left and right strobes are never high in the same cycle.
- R9: `fmt` = 3 behaves exactly as left-justified.
- R10: No word is delivered before the first frame-clock transition after reset. In right-justified mode, only half-frames that began with an observed transition produce a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, faster than twice the bit clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk | input | 1 | Serial bit clock |
| lrclk | input | 1 | Frame (channel select) clock |
| sdata | input | 1 | Serial data, MSB first |
| fmt | input | 2 | 0 I2S, 1 left-justified, 2 right-justified, 3 as 1 |
| wlen | input | 2 | 0:16, 1:18, 2:20, 3:24 bits |
| left_pcm | output | 24 | Last left sample, left-aligned |
| right_pcm | output | 24 | Last right sample, left-aligned |
| left_valid | output | 1 | One-cycle strobe for a new left sample |
| right_valid | output | 1 | One-cycle strobe for a new right sample |

## Verification
The hardest case to reach is the word whose last bit falls outside its own half-frame. In I2S this happens when a 16-bit word fills a 16-clock half, so its LSB lands after the frame-clock edge. In right-justified mode the final word of a stream only appears once a further transition arrives. The stimulus is built as a complete bit list before it is played. Each word is written at its format's position after the filler bits are randomised, and a short tail half-frame closes the stream. Every stream opens with a single-bit MSB word and an LSB-only word, so an offset of one position in either direction changes the received value.

// File: rtl/serial_audio_rx.sv
module serial_audio_rx #(
  parameter int PCM_W = 24,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bclk,
  input  logic             lrclk,
  input  logic             sdata,
  input  logic [1:0]       fmt,
  input  logic [1:0]       wlen,
  output logic [PCM_W-1:0] left_pcm,
  output logic [PCM_W-1:0] right_pcm,
  output logic             left_valid,
  output logic             right_valid
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [2:0] sync1, sync2;
  logic       bclk_q, primed, lr_q, eff_q, seen;
  logic [CNT_W-1:0] cnt, cnt_n;
  logic [PCM_W-1:0] sh, sh_n;
  logic [4:0] nbits;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= '0;
      sync2 <= '0;
      bclk_q <= 1'b0;
    end else begin
      sync1 <= {bclk, lrclk, sdata};
      sync2 <= sync1;
      bclk_q <= sync2[2];
    end
  end

  wire rise  = sync2[2] & ~bclk_q;
  wire lr_s  = sync2[1];
  wire sd_s  = sync2[0];
  wire is_i2s = (fmt == 2'd0);
  wire is_rj  = (fmt == 2'd2);

  always_comb begin
    case (wlen)
      2'd0: nbits = 5'd16;
      2'd1: nbits = 5'd18;
      2'd2: nbits = 5'd20;
      default: nbits = 5'd24;
    endcase
  end

  wire eff    = is_i2s ? lr_q : lr_s;
  wire tr     = primed && (eff != eff_q);
  wire seen_n = seen | tr;
  assign cnt_n = tr ? '0 : ((cnt == CNT_MAX) ? cnt : cnt + 1'b1);
  assign sh_n  = {sh[PCM_W-2:0], sd_s};

  wire [PCM_W-1:0] word_just = sh_n << (PCM_W - nbits);
  wire [PCM_W-1:0] word_rj   = sh << (PCM_W - nbits);
  wire emit_just = !is_rj && seen_n && (cnt_n == CNT_W'(nbits) - CNT_W'(1));
  wire left_just = is_i2s ? !eff : eff;
  wire emit_rj   = is_rj && tr && seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      primed <= 1'b0;
      lr_q <= 1'b0;
      eff_q <= 1'b0;
      seen <= 1'b0;
      cnt <= '0;
      sh <= '0;
      left_pcm <= '0;
      right_pcm <= '0;
      left_valid <= 1'b0;
      right_valid <= 1'b0;
    end else begin
      left_valid <= 1'b0;
      right_valid <= 1'b0;
      if (rise) begin
        lr_q <= lr_s;
        if (!primed) begin
          primed <= 1'b1;
          eff_q <= lr_s;
          cnt <= '0;
        end else begin
          eff_q <= eff;
          cnt <= cnt_n;
          seen <= seen_n;
          sh <= sh_n;
          if (emit_just) begin
            if (left_just) begin
              left_pcm <= word_just;
              left_valid <= 1'b1;
            end else begin
              right_pcm <= word_just;
              right_valid <= 1'b1;
            end
          end
          if (emit_rj) begin
            if (eff_q) begin
              left_pcm <= word_rj;
              left_valid <= 1'b1;
            end else begin
              right_pcm <= word_rj;
              right_valid <= 1'b1;
            end
          end
        end
      end
    end
  end

  a_r8_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(left_valid && right_valid));
  a_r8_left_pulse: assert property (@(posedge clk) disable iff (rst)
    left_valid |=> !left_valid);
  a_r8_right_pulse: assert property (@(posedge clk) disable iff (rst)
    right_valid |=> !right_valid);
  a_r6_left_zero_fill: assert property (@(posedge clk) disable iff (rst)
    left_valid |-> (left_pcm << nbits) == '0);
  a_r6_right_zero_fill: assert property (@(posedge clk) disable iff (rst)
    right_valid |-> (right_pcm << nbits) == '0);
  a_r2_word_end: assert property (@(posedge clk) disable iff (rst)
    ((left_valid || right_valid) && !is_rj) |-> cnt == CNT_W'(nbits) - CNT_W'(1));
  a_r4_on_transition: assert property (@(posedge clk) disable iff (rst)
    ((left_valid || right_valid) && is_rj) |-> cnt == '0);
  a_r10_needs_transition: assert property (@(posedge clk) disable iff (rst)
    (left_valid || right_valid) |-> seen);
endmodule

// File: tb/serial_audio_rx_test.sv
`timescale 1ns/1ps
module serial_audio_rx_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bclk = 1'b0, lrclk = 1'b0, sdata = 1'b0;
  logic [1:0] fmt = 2'd1, wlen = 2'd0;
  logic [23:0] left_pcm, right_pcm;
  logic left_valid, right_valid;

  always #4 clk = ~clk;

  serial_audio_rx uut (
    .clk(clk), .rst(rst), .bclk(bclk), .lrclk(lrclk), .sdata(sdata),
    .fmt(fmt), .wlen(wlen), .left_pcm(left_pcm), .right_pcm(right_pcm),
    .left_valid(left_valid), .right_valid(right_valid)
  );

  int vectors = 0, errors = 0;
  logic sd_arr [0:1023];
  logic lr_arr [0:1023];
  int   len;
  logic [23:0] exp_l [0:7];
  logic [23:0] exp_r [0:7];
  logic [23:0] got_l [0:15];
  logic [23:0] got_r [0:15];
  int nl = 0, nr = 0;

  always @(negedge clk) begin
    if (rst) begin
      nl = 0;
      nr = 0;
    end else begin
      if (left_valid && nl < 16) begin got_l[nl] = left_pcm; nl++; end
      if (right_valid && nr < 16) begin got_r[nr] = right_pcm; nr++; end
    end
  end

  function automatic int bits_of(input logic [1:0] w);
    case (w)
      2'd0: return 16;
      2'd1: return 18;
      2'd2: return 20;
      default: return 24;
    endcase
  endfunction

  function automatic logic [23:0] align(input logic [23:0] w, input int n);
    return w << (24 - n);
  endfunction

  function automatic string tag_of(input logic [1:0] f);
    case (f)
      2'd0: return "R3";
      2'd2: return "R4";
      2'd3: return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic check(input string tag, input logic [23:0] got, input logic [23:0] exp);
    vectors++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic place(input int base, input int h, input int n, input logic [23:0] w);
    for (int k = 0; k < n; k++) begin
      int pos;
      if (fmt == 2'd0) pos = base + 1 + k;
      else if (fmt == 2'd2) pos = base + h - n + k;
      else pos = base + k;
      sd_arr[pos] = w[n-1-k];
    end
  endtask

  task automatic run_stream(input logic [1:0] f, input logic [1:0] wl, input int h, input int frames);
    int n;
    logic lv;
    int base;
    string tg;
    n = bits_of(wl);
    tg = tag_of(f);
    lv = (f == 2'd0) ? 1'b0 : 1'b1;
    @(negedge clk);
    rst = 1'b1;
    fmt = f;
    wlen = wl;
    bclk = 1'b0;
    lrclk = ~lv;
    sdata = 1'b0;
    repeat (6) @(negedge clk);
    if (vectors == 0) begin
      check("R1 left_pcm", left_pcm, 24'h0);
      check("R1 right_pcm", right_pcm, 24'h0);
      check("R1 strobes", {22'd0, left_valid, right_valid}, 24'h0);
    end
    rst = 1'b0;
    @(negedge clk);
    if (vectors == 3)
      check("R1 after release", {left_pcm[0], right_pcm[0], left_valid, right_valid}, 24'h0);
    for (int i = 0; i < 1024; i++) sd_arr[i] = 1'($urandom);
    for (int fr = 0; fr < frames; fr++) begin
      if (fr == 0) begin
        exp_l[fr] = 24'(1) << (n - 1);
        exp_r[fr] = 24'd1;
      end else if (fr == 1) begin
        exp_l[fr] = (24'(1) << n) - 24'd1;
        exp_r[fr] = 24'd0;
      end else begin
        exp_l[fr] = 24'($urandom) & ((24'(1) << n) - 24'd1);
        exp_r[fr] = 24'($urandom) & ((24'(1) << n) - 24'd1);
      end
    end
    len = 0;
    for (int i = 0; i < 4; i++) begin lr_arr[len] = ~lv; len++; end
    for (int fr = 0; fr < frames; fr++) begin
      for (int ch = 0; ch < 2; ch++) begin
        base = len;
        for (int b = 0; b < h; b++) begin lr_arr[len] = (ch == 0) ? lv : ~lv; len++; end
        place(base, h, n, (ch == 0) ? exp_l[fr] : exp_r[fr]);
      end
    end
    for (int i = 0; i < 3; i++) begin lr_arr[len] = lv; len++; end
    for (int i = 0; i < len; i++) begin
      sdata = sd_arr[i];
      lrclk = lr_arr[i];
      repeat (4) @(negedge clk);
      bclk = 1'b1;
      repeat (4) @(negedge clk);
      bclk = 1'b0;
    end
    repeat (12) @(negedge clk);
    // R10: exact counts, nothing before the first transition
    check({tg, " R10 left count"}, 24'(nl), 24'(frames));
    check({tg, " R10 right count"}, 24'(nr), 24'(frames));
    for (int fr = 0; fr < frames && fr < nl; fr++)
      check({tg, " R5 R6 R7 left word"}, got_l[fr], align(exp_l[fr], n));
    for (int fr = 0; fr < frames && fr < nr; fr++)
      check({tg, " R5 R6 R7 right word"}, got_r[fr], align(exp_r[fr], n));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    run_stream(2'd1, 2'd3, 32, 4);
    run_stream(2'd0, 2'd0, 16, 4);
    run_stream(2'd2, 2'd0, 16, 4);
    run_stream(2'd2, 2'd3, 32, 4);
    run_stream(2'd0, 2'd2, 24, 4);
    run_stream(2'd3, 2'd1, 24, 4);
    run_stream(2'd2, 2'd1, 24, 4);
    run_stream(2'd0, 2'd3, 32, 4);
    run_stream(2'd1, 2'd0, 32, 4);
    run_stream(2'd0, 2'd3, 24, 4);
    run_stream(2'd2, 2'd3, 24, 4);
    for (int r = 0; r < 6; r++) begin
      logic [1:0] f, wl;
      int h;
      f = 2'($urandom_range(0, 3));
      wl = 2'($urandom_range(0, 3));
      h = (wl == 2'd0) ? 16 * $urandom_range(1, 2) : 32;
      if (wl == 2'd0 && $urandom_range(0, 1) == 1) h = 24;
      if (wl != 2'd0 && $urandom_range(0, 1) == 1) h = 24;
      run_stream(f, wl, h, 4);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule